// File: doc/BRIEF.md
# Sector-Locking Instruction Cache

This block sits between an instruction fetch unit and a slower program memory. Its storage is split into a small number of sectors. Each sector owns one tag register that names a whole run of consecutive instruction words, and every word in the sector has its own valid bit. A fetch whose sector tag matches and whose word is valid is answered in the same cycle. Any other fetch stalls the requester while the cache fetches words from the missing address up to the end of that word's aligned four-word group.

Replacement uses a recency list of sectors. The list is reordered whenever a sector is hit or receives a fill. The victim is the least recently used sector that is not locked. Software-style commands can pin a sector in place (lock), release it (unlock), or discard every sector that is not pinned (flush-unlocked). When every sector is pinned, a missing word is fetched from memory and handed straight to the requester without being stored.

Top module: `icache_sect_lock`

## Requirements
- R1: After reset no sector is present or locked, and with no request pending `fetch_hit`, `fetch_stall` and `mem_req` are all low.
- R2: On a miss, the cache requests words at ascending addresses starting at the missing address and ending at the last word of its aligned four-word group. Address bits [1:0] of 00, 01, 10 and 11 therefore give 4, 3, 2 and 1 memory words.
- R3: A fetch that hits asserts `fetch_hit` in the same cycle as `fetch_req`, keeps `fetch_stall` low, and makes no memory request.
- R4: The word returned on `fetch_data` while `fetch_hit` is high equals the memory content at `fetch_addr`.
- R5: One tag covers every word of a sector. A fetch whose tag matches a present sector, but whose word is not yet valid, fills only that word's group into the same sector, and the words already held there stay valid.
- R6: A miss on a tag that no sector holds replaces the unlocked sector that was least recently hit or filled.
- R7: A locked sector is never chosen for replacement and keeps its tag and its words.
- R8: The command `cmd_op`=2'b11 (flush-unlocked) invalidates every sector that is not locked and leaves locked sectors as they are.
- R9: The command `cmd_op`=2'b01 (lock) on an address whose tag no sector holds first allocates the least recently used unlocked sector for that tag, with all its words invalid, and then locks it. If the tag is already held, the command only locks that sector.
- R10: The command `cmd_op`=2'b10 (unlock) clears the lock of the sector holding the tag of `cmd_addr`, so a later flush-unlocked removes that sector.
- R11: When every sector is locked and no sector holds the tag, a miss fetches only the missing word. That word is presented with `fetch_hit` one cycle after the memory acknowledge and is not stored, so a repeat fetch goes to memory again.
- R12: Commands are taken only while no fill or bypass is in progress. In such a cycle a valid command takes priority over a fetch, and `cmd_op`=2'b00 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Instruction fetch request, held until `fetch_hit` |
| fetch_addr | input | ADDR_W | Word address of the fetch |
| fetch_data | output | DATA_W | Instruction word, valid while `fetch_hit` is high |
| fetch_hit | output | 1 | Fetched word delivered this cycle |
| fetch_stall | output | 1 | Request pending but word not yet available |
| mem_req | output | 1 | Word request to program memory |
| mem_addr | output | ADDR_W | Address of the requested memory word |
| mem_data | input | DATA_W | Word returned by memory |
| mem_ack | input | 1 | `mem_data` is valid for `mem_addr` this cycle |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 lock, 10 unlock, 11 flush-unlocked, 00 none |
| cmd_addr | input | ADDR_W | Address whose tag the lock or unlock command names |

## Verification
Faults in the tag or valid state show up at the ports on the very next fetch to the affected address. Such a fetch either hits with no memory traffic when it should not, or stalls and raises `mem_req` when it should hit. The number of acknowledged words and the first and last address of each fill show whether the group boundary was computed correctly. A corrupted recency list or lock mask only shows up after enough allocations to cycle through every sector. For that reason the scenarios fill all sectors before probing which tag was evicted, and then probe both the survivor and the victim.

// File: rtl/icache_pkg.sv
package icache_pkg;
   typedef enum logic [1:0] {
      CMD_NONE   = 2'b00,
      CMD_LOCK   = 2'b01,
      CMD_UNLOCK = 2'b10,
      CMD_FLUSH  = 2'b11
   } icache_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FILL,
      ST_BYP,
      ST_BYPD
   } icache_state_e;
endpackage

// File: rtl/icache_tag_match.sv
module icache_tag_match #(
   parameter int N     = 8,
   parameter int TAG_W = 17,
   parameter int ID_W  = 3
) (
   input  logic [N-1:0][TAG_W-1:0] tags,
   input  logic [N-1:0]            present,
   input  logic [TAG_W-1:0]        key,
   output logic [N-1:0]            match,
   output logic [ID_W-1:0]         match_id,
   output logic                    match_any
);
   for (genvar s = 0; s < N; s++) begin : g_cmp
      assign match[s] = present[s] && (tags[s] == key);
   end

   always_comb begin
      match_id = '0;
      for (int s = 0; s < N; s++)
         if (match[s]) match_id = ID_W'(s);
   end

   assign match_any = |match;
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
   parameter int N    = 8,
   parameter int ID_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            touch_en,
   input  logic [ID_W-1:0] touch_id,
   input  logic [N-1:0]    lock_mask,
   output logic [ID_W-1:0] victim_id,
   output logic            victim_ok
);
   logic [ID_W-1:0] order_q [N];
   logic [ID_W-1:0] pos;
   logic [N-1:0]    seen;

   always_comb begin
      pos = '0;
      for (int i = 0; i < N; i++)
         if (order_q[i] == touch_id) pos = ID_W'(i);
   end

   // entry 0 is most recent; the last unlocked entry found wins
   always_comb begin
      victim_id = '0;
      victim_ok = 1'b0;
      for (int i = 0; i < N; i++)
         if (!lock_mask[order_q[i]]) begin
            victim_id = order_q[i];
            victim_ok = 1'b1;
         end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) order_q[i] <= ID_W'(i);
      end else if (touch_en) begin
         for (int i = 0; i < N; i++) begin
            if (i == 0)                order_q[i] <= touch_id;
            else if (ID_W'(i) <= pos)  order_q[i] <= order_q[i-1];
         end
      end
   end

   always_comb begin
      seen = '0;
      for (int i = 0; i < N; i++) seen[order_q[i]] = 1'b1;
   end

   // R6
   order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen == {N{1'b1}});
endmodule

// File: rtl/icache_sect_lock.sv
module icache_sect_lock
   import icache_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int DATA_W     = 24,
   parameter int NUM_SECT   = 8,
   parameter int SECT_WORDS = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic [DATA_W-1:0] fetch_data,
   output logic              fetch_hit,
   output logic              fetch_stall,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_data,
   input  logic              mem_ack,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr
);
   localparam int OFF_W = $clog2(SECT_WORDS);
   localparam int TAG_W = ADDR_W - OFF_W;
   localparam int ID_W  = $clog2(NUM_SECT);
   localparam int DEPTH = NUM_SECT * SECT_WORDS;

   if (SECT_WORDS < 4 || (1 << OFF_W) != SECT_WORDS) begin : g_bad_words
      $error("SECT_WORDS must be a power of two of at least 4");
   end
   if (NUM_SECT < 2 || (1 << ID_W) != NUM_SECT) begin : g_bad_sect
      $error("NUM_SECT must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the sector offset width");
   end

   icache_state_e                       state;
   logic [NUM_SECT-1:0][TAG_W-1:0]      tag_q;
   logic [NUM_SECT-1:0]                 present_q, lock_q;
   logic [NUM_SECT-1:0][SECT_WORDS-1:0] valid_q;
   logic [DATA_W-1:0]                   data_mem [DEPTH];
   logic [ID_W-1:0]                     fill_id;
   logic [ADDR_W-1:0]                   fill_addr;
   logic [DATA_W-1:0]                   byp_data;

   logic [TAG_W-1:0]    lk_tag, cmd_tag;
   logic [OFF_W-1:0]    lk_off, fill_off;
   logic [NUM_SECT-1:0] lk_match, c_match;
   logic [ID_W-1:0]     match_id, c_id, victim_id, touch_id;
   logic                match_any, c_any, victim_ok, touch_en;
   logic                idle, cmd_go, fetch_go, lk_hit, hit_now, miss_now;
   icache_cmd_e         cmd_e;
   logic                unused_cmd_low;

   assign lk_tag         = fetch_addr[ADDR_W-1:OFF_W];
   assign lk_off         = fetch_addr[OFF_W-1:0];
   assign cmd_tag        = cmd_addr[ADDR_W-1:OFF_W];
   assign fill_off       = fill_addr[OFF_W-1:0];
   assign cmd_e          = icache_cmd_e'(cmd_op);
   assign unused_cmd_low = ^cmd_addr[OFF_W-1:0];

   icache_tag_match #(.N(NUM_SECT), .TAG_W(TAG_W), .ID_W(ID_W)) u_fetch_match (
      .tags(tag_q), .present(present_q), .key(lk_tag),
      .match(lk_match), .match_id(match_id), .match_any(match_any));

   icache_tag_match #(.N(NUM_SECT), .TAG_W(TAG_W), .ID_W(ID_W)) u_cmd_match (
      .tags(tag_q), .present(present_q), .key(cmd_tag),
      .match(c_match), .match_id(c_id), .match_any(c_any));

   icache_lru #(.N(NUM_SECT), .ID_W(ID_W)) u_lru (
      .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_id(touch_id),
      .lock_mask(lock_q), .victim_id(victim_id), .victim_ok(victim_ok));

   assign idle     = (state == ST_IDLE);
   assign cmd_go   = idle && cmd_valid;
   assign fetch_go = idle && fetch_req && !cmd_valid;
   assign lk_hit   = match_any && valid_q[match_id][lk_off];
   assign hit_now  = fetch_go && lk_hit;
   assign miss_now = fetch_go && !lk_hit;

   assign touch_en = hit_now
                   || (miss_now && (match_any || victim_ok))
                   || (cmd_go && cmd_e == CMD_LOCK && (c_any || victim_ok));
   assign touch_id = cmd_go ? (c_any ? c_id : victim_id)
                            : (match_any ? match_id : victim_id);

   assign fetch_hit   = hit_now || (state == ST_BYPD);
   assign fetch_data  = (state == ST_BYPD) ? byp_data : data_mem[{match_id, lk_off}];
   assign fetch_stall = fetch_req && !fetch_hit;
   assign mem_req     = (state == ST_FILL) || (state == ST_BYP);
   assign mem_addr    = fill_addr;

   always_ff @(posedge clk) begin
      if (state == ST_FILL && mem_ack) data_mem[{fill_id, fill_off}] <= mem_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tag_q     <= '0;
         present_q <= '0;
         lock_q    <= '0;
         valid_q   <= '0;
         fill_id   <= '0;
         fill_addr <= '0;
         byp_data  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cmd_go) begin
                  case (cmd_e)
                     CMD_LOCK: begin
                        if (c_any) lock_q[c_id] <= 1'b1;
                        else if (victim_ok) begin
                           tag_q[victim_id]     <= cmd_tag;
                           present_q[victim_id] <= 1'b1;
                           lock_q[victim_id]    <= 1'b1;
                           valid_q[victim_id]   <= '0;
                        end
                     end
                     CMD_UNLOCK: if (c_any) lock_q[c_id] <= 1'b0;
                     CMD_FLUSH:  present_q <= present_q & lock_q;
                     default: ;
                  endcase
               end else if (miss_now) begin
                  fill_addr <= fetch_addr;
                  if (match_any) begin
                     fill_id <= match_id;
                     state   <= ST_FILL;
                  end else if (victim_ok) begin
                     fill_id              <= victim_id;
                     tag_q[victim_id]     <= lk_tag;
                     present_q[victim_id] <= 1'b1;
                     valid_q[victim_id]   <= '0;
                     state                <= ST_FILL;
                  end else begin
                     state <= ST_BYP;
                  end
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  valid_q[fill_id][fill_off] <= 1'b1;
                  fill_addr                  <= fill_addr + 1'b1;
                  if (fill_addr[1:0] == 2'b11) state <= ST_IDLE;
               end
            end
            ST_BYP: begin
               if (mem_ack) begin
                  byp_data <= mem_data;
                  state    <= ST_BYPD;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   // R2
   burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && mem_ack && mem_addr[1:0] == 2'b11) |=> !mem_req);

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && mem_ack && mem_addr[1:0] != 2'b11)
         |=> (mem_req && mem_addr == $past(mem_addr) + 1'b1));

   // R8
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && cmd_e == CMD_FLUSH) |=> ((present_q & ~lock_q) == '0));

   // R11
   bypass_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BYP && mem_ack) |=> (fetch_hit && fetch_data == $past(mem_data)));

   for (genvar s = 0; s < NUM_SECT; s++) begin : g_lock_chk
      // R7
      locked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (lock_q[s] && $past(lock_q[s]))
            |-> (present_q[s] && tag_q[s] == $past(tag_q[s])));
   end
endmodule

// File: tb/icache_sect_lock_tb.sv
`timescale 1ns/1ps
module icache_sect_lock_tb;
   localparam int AW = 24;
   localparam int DW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_req = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic [DW-1:0] fetch_data;
   logic          fetch_hit, fetch_stall, mem_req;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data = '0;
   logic          mem_ack = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [AW-1:0] cmd_addr = '0;

   int checks = 0;
   int errors = 0;
   int acks = 0;
   logic [AW-1:0] first_a, last_a;
   bit done = 1'b0;

   always #4 clk = ~clk;

   icache_sect_lock u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_data(fetch_data), .fetch_hit(fetch_hit), .fetch_stall(fetch_stall),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr));

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return (a * 24'd3) ^ 24'h00A5C3;
   endfunction

   always @(posedge clk) begin
      mem_ack  <= mem_req && !mem_ack;
      mem_data <= memf(mem_addr);
   end

   always @(posedge clk) begin
      if (mem_ack) begin
         if (acks == 0) first_a = mem_addr;
         last_a = mem_addr;
         acks++;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_fetch(input logic [AW-1:0] a, output int waitc, output logic [DW-1:0] d);
      @(negedge clk);
      acks = 0;
      fetch_req  = 1'b1;
      fetch_addr = a;
      waitc = 0;
      #1;
      while (!fetch_hit && waitc < 200) begin
         @(negedge clk);
         #1;
         waitc++;
      end
      d = fetch_data;
      @(negedge clk);
      fetch_req = 1'b0;
   endtask

   task automatic fetch_expect(input string req, input logic [AW-1:0] a, input int exp_acks);
      int w;
      logic [DW-1:0] d;
      do_fetch(a, w, d);
      chk(req, $sformatf("acks @%0h", a), acks, exp_acks);
      chk("R4", $sformatf("data @%0h", a), int'(d), int'(memf(a)));
      if (exp_acks == 0) chk("R3", $sformatf("wait @%0h", a), w, 0);
   endtask

   task automatic command(input logic [1:0] op, input logic [AW-1:0] a);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = a;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 2'b00;
   endtask

   task automatic t_reset;
      #1;
      chk("R1", "hit after reset", int'(fetch_hit), 0);
      chk("R1", "stall after reset", int'(fetch_stall), 0);
      chk("R1", "mem_req after reset", int'(mem_req), 0);
   endtask

   task automatic t_burst;
      command(2'b00, 24'h0);
      fetch_expect("R2", 24'h2000, 4);
      chk("R2", "first addr", int'(first_a), 'h2000);
      chk("R2", "last addr", int'(last_a), 'h2003);
      fetch_expect("R3", 24'h2000, 0);
      fetch_expect("R2", 24'h2006, 2);
      chk("R2", "last addr 10", int'(last_a), 'h2007);
      fetch_expect("R2", 24'h200B, 1);
      fetch_expect("R2", 24'h2011, 3);
      chk("R2", "first addr 01", int'(first_a), 'h2011);
      fetch_expect("R5", 24'h2000, 0);
      fetch_expect("R5", 24'h2007, 0);
   endtask

   task automatic t_lru;
      command(2'b11, 24'h0);
      for (int k = 0; k < 8; k++) fetch_expect("R6", 24'h4000 + k * 'h80, 4);
      fetch_expect("R6", 24'h4000, 0);
      fetch_expect("R6", 24'h4400, 4);
      fetch_expect("R6", 24'h4000, 0);
      fetch_expect("R6", 24'h4100, 0);
      fetch_expect("R6", 24'h4080, 4);
   endtask

   task automatic t_lock_flush;
      command(2'b11, 24'h0);
      command(2'b01, 24'h6000);
      fetch_expect("R9", 24'h6000, 4);
      for (int k = 0; k < 8; k++) fetch_expect("R7", 24'hA000 + k * 'h80, 4);
      fetch_expect("R7", 24'h6000, 0);
      command(2'b11, 24'h0);
      fetch_expect("R8", 24'h6000, 0);
      fetch_expect("R8", 24'hA380, 4);
      command(2'b10, 24'h6000);
      command(2'b11, 24'h0);
      fetch_expect("R10", 24'h6000, 4);
   endtask

   task automatic t_bypass;
      command(2'b11, 24'h0);
      for (int k = 0; k < 8; k++) command(2'b01, 24'h8000 + k * 'h80);
      fetch_expect("R11", 24'h9000, 1);
      chk("R11", "bypass addr", int'(first_a), 'h9000);
      fetch_expect("R11", 24'h9000, 1);
      fetch_expect("R9", 24'h8000, 4);
      fetch_expect("R9", 24'h8000, 0);
   endtask

   task automatic t_cmd_prio;
      int w;
      // R12: fetch held with a command pending is not served that cycle
      @(negedge clk);
      fetch_req  = 1'b1;
      fetch_addr = 24'h8000;
      cmd_valid  = 1'b1;
      cmd_op     = 2'b00;
      #1;
      chk("R12", "hit while command", int'(fetch_hit), 0);
      @(negedge clk);
      cmd_valid = 1'b0;
      #1;
      chk("R12", "hit after command", int'(fetch_hit), 1);
      @(negedge clk);
      fetch_req = 1'b0;
      w = 0;
      fetch_expect("R12", 24'h8000, w);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_burst();
      t_lru();
      t_lock_flush();
      t_bypass();
      t_cmd_prio();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      #(200000 * 8);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule